// File: doc/BRIEF.md
# D-PHY Clock Lane Sequencer

This block controls the two enable lines of one high-speed clock lane transmitter. The lane rests in the low-power stop state. On request, it moves through a prepare phase and a zero phase into continuous high-speed clocking. It waits a programmable lead time before it tells the data lanes they may start. On a stop request it runs a post phase and a trail phase, then returns to low-power stop. Every phase length comes from a byte-wide field and is counted in lane byte-clock periods. One byte-clock period equals eight high-speed bit periods.

Software can take over each enable line on its own through a select/value bit pair, and the state machine keeps running underneath. A power-down bit idles the whole lane at once. A synchronous soft reset returns the sequencer to stop on the next edge. All pins are plain control and status lines with no handshake. The two requests are levels that the block samples on every rising clock edge.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: After rst_n is released, and in the stop state, tx_lp_en=1 and tx_hs_en=0. status is 4'b0100, with the bits ordered [3] ready, [2] tx_stop, [1] tx_ulps, [0] tx_hs_active.
- R2: The field positions in tim_word are: prepare count in [31:24], zero count in [23:16], post count in [15:8] and trail count in [7:0]. The lead-time count arrives separately on pre_tim.
- R3: hs_start sampled high in the stop state starts the prepare phase on the next cycle. Prepare lasts max(prepare,1) cycles with both enables low and status 4'b0000.
- R4: The zero phase follows prepare. It lasts max(zero,1) cycles with tx_hs_en=1, tx_lp_en=0 and status 4'b0000.
- R5: The lead phase follows zero. It lasts max(pre,1) cycles with tx_hs_en=1 and status 4'b0001. After it, the lane is ready, with status 4'b1001 and tx_hs_en=1.
- R6: hs_stop sampled high while ready starts the post phase on the next cycle. Post lasts max(post,1) cycles with tx_hs_en=1 and status 4'b0001. Trail follows for max(trail,1) cycles with tx_hs_en=1 and status 4'b0000. The lane then returns to stop.
- R7: A field value of zero gives a one-cycle phase, so no phase is ever skipped.
- R8: hs_start has no effect outside the stop state. hs_stop has no effect outside the ready state. When both are high in stop, the entry sequence starts.
- R9: When hs_sel=1, tx_hs_en equals hs_val. When lp_sel=1, tx_lp_en equals lp_val. An override does not change the state machine or status.
- R10: While pwr_dn=1, tx_hs_en, tx_lp_en and status are all 0 in the same cycle, whatever the overrides are set to. The sequencer is in stop from the next edge onward.
- R11: soft_rst sampled high returns the sequencer to stop on the next edge, from any phase.
- R12: tx_ulps (status[1]) is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous active-high return to stop |
| pwr_dn | input | 1 | Lane and PHY power-down; idles every output |
| hs_start | input | 1 | Request to enter high-speed clocking |
| hs_stop | input | 1 | Request to leave high-speed clocking |
| tim_word | input | 32 | Packed prepare, zero, post and trail counts |
| pre_tim | input | 8 | Lead-time count before ready |
| hs_sel | input | 1 | Take tx_hs_en from hs_val |
| hs_val | input | 1 | Override value for tx_hs_en |
| lp_sel | input | 1 | Take tx_lp_en from lp_val |
| lp_val | input | 1 | Override value for tx_lp_en |
| tx_hs_en | output | 1 | High-speed driver enable |
| tx_lp_en | output | 1 | Low-power driver enable |
| status | output | 4 | {ready, tx_stop, tx_ulps, tx_hs_active} |

## Verification
A request sampled at one edge shows at the outputs just after that edge. Each phase then holds for exactly its max(field,1) cycles, with no added latency. The bench therefore drives inputs shortly after a rising edge and samples one time unit later. It walks each phase sample by sample and checks that the expected value appears on every one of those cycles and that the next phase starts on the following cycle. Overrides and power-down act combinationally, so those checks sample in the same cycle as the drive. The return to stop caused by power-down or soft reset is checked one edge later.

// File: rtl/dphy_clk_pkg.sv
package dphy_clk_pkg;
  typedef enum logic [2:0] {
    ST_STOP, ST_PREP, ST_ZERO, ST_LEAD, ST_READY, ST_POST, ST_TRAIL
  } lane_st_e;

  typedef struct packed {
    logic ready;
    logic tx_stop;
    logic tx_ulps;
    logic hs_active;
  } lane_sts_t;
endpackage

// File: rtl/dphy_phase_timer.sv
module dphy_phase_timer #(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] ld_val,
  output logic               done
);
  logic [FIELD_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= (ld_val == '0) ? '0 : ld_val - 1'b1;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R7
  zero_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ld_val <= FIELD_W'(1)) |=> done);
endmodule

// File: rtl/dphy_clk_fsm.sv
module dphy_clk_fsm
  import dphy_clk_pkg::*;
#(
  parameter int FIELD_W = 8,
  localparam int TIM_W = 4 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               pwr_dn,
  input  logic               hs_start,
  input  logic               hs_stop,
  input  logic [TIM_W-1:0]   tim_word,
  input  logic [FIELD_W-1:0] pre_tim,
  output logic               fsm_hs,
  output logic               fsm_lp,
  output lane_sts_t          sts
);
  lane_st_e st, nxt;
  logic load, tmr_done;
  logic [FIELD_W-1:0] ld_val;
  logic [FIELD_W-1:0] f_prep, f_zero, f_post, f_trail;

  assign f_prep  = tim_word[4*FIELD_W-1:3*FIELD_W];
  assign f_zero  = tim_word[3*FIELD_W-1:2*FIELD_W];
  assign f_post  = tim_word[2*FIELD_W-1:FIELD_W];
  assign f_trail = tim_word[FIELD_W-1:0];

  dphy_phase_timer #(.FIELD_W(FIELD_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_val(ld_val), .done(tmr_done)
  );

  always_comb begin
    nxt = st;
    load = 1'b0;
    ld_val = '0;
    if (soft_rst || pwr_dn) nxt = ST_STOP;
    else begin
      case (st)
        ST_STOP:  if (hs_start) begin nxt = ST_PREP; load = 1'b1; ld_val = f_prep; end
        ST_PREP:  if (tmr_done) begin nxt = ST_ZERO; load = 1'b1; ld_val = f_zero; end
        ST_ZERO:  if (tmr_done) begin nxt = ST_LEAD; load = 1'b1; ld_val = pre_tim; end
        ST_LEAD:  if (tmr_done) nxt = ST_READY;
        ST_READY: if (hs_stop) begin nxt = ST_POST; load = 1'b1; ld_val = f_post; end
        ST_POST:  if (tmr_done) begin nxt = ST_TRAIL; load = 1'b1; ld_val = f_trail; end
        ST_TRAIL: if (tmr_done) nxt = ST_STOP;
        default:  nxt = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_STOP;
    else st <= nxt;
  end

  always_comb begin
    fsm_hs = 1'b0;
    fsm_lp = 1'b0;
    sts = '0;
    case (st)
      ST_STOP:  begin fsm_lp = 1'b1; sts.tx_stop = 1'b1; end
      ST_ZERO,
      ST_TRAIL: fsm_hs = 1'b1;
      ST_LEAD,
      ST_POST:  begin fsm_hs = 1'b1; sts.hs_active = 1'b1; end
      ST_READY: begin fsm_hs = 1'b1; sts.hs_active = 1'b1; sts.ready = 1'b1; end
      default:  ;
    endcase
  end

  // R3
  start_to_prep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STOP && hs_start && !soft_rst && !pwr_dn) |=> (st == ST_PREP));
  // R6
  trail_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TRAIL && tmr_done) |=> (st == ST_STOP));
  // R5
  ready_has_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts.ready |-> fsm_hs);
  // R11
  softrst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (st == ST_STOP));
endmodule

// File: rtl/dphy_en_override.sv
module dphy_en_override #(
  parameter int N_SIG = 2
) (
  input  logic             pwr_dn,
  input  logic [N_SIG-1:0] fsm_val,
  input  logic [N_SIG-1:0] sel,
  input  logic [N_SIG-1:0] reg_val,
  output logic [N_SIG-1:0] en_out
);
  for (genvar i = 0; i < N_SIG; i++) begin : g_mux
    assign en_out[i] = !pwr_dn && (sel[i] ? reg_val[i] : fsm_val[i]);
  end
endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
  import dphy_clk_pkg::*;
#(
  parameter int FIELD_W = 8,
  localparam int TIM_W = 4 * FIELD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst,
  input  logic               pwr_dn,
  input  logic               hs_start,
  input  logic               hs_stop,
  input  logic [TIM_W-1:0]   tim_word,
  input  logic [FIELD_W-1:0] pre_tim,
  input  logic               hs_sel,
  input  logic               hs_val,
  input  logic               lp_sel,
  input  logic               lp_val,
  output logic               tx_hs_en,
  output logic               tx_lp_en,
  output logic [3:0]         status
);
  logic fsm_hs, fsm_lp;
  lane_sts_t sts;
  logic [1:0] en_out;

  dphy_clk_fsm #(.FIELD_W(FIELD_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pwr_dn(pwr_dn),
    .hs_start(hs_start), .hs_stop(hs_stop), .tim_word(tim_word),
    .pre_tim(pre_tim), .fsm_hs(fsm_hs), .fsm_lp(fsm_lp), .sts(sts)
  );

  dphy_en_override #(.N_SIG(2)) u_ovr (
    .pwr_dn(pwr_dn), .fsm_val({fsm_lp, fsm_hs}), .sel({lp_sel, hs_sel}),
    .reg_val({lp_val, hs_val}), .en_out(en_out)
  );

  assign tx_hs_en = en_out[0];
  assign tx_lp_en = en_out[1];
  assign status   = pwr_dn ? 4'b0000 : sts;

  // R10
  pwrdn_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!tx_hs_en && !tx_lp_en && status == 4'b0000));
endmodule

// File: tb/dphy_clk_lane_seq_bench.sv
module dphy_clk_lane_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, pwr_dn = 0, hs_start = 0, hs_stop = 0;
  logic [31:0] tim_word = '0;
  logic [7:0] pre_tim = '0;
  logic hs_sel = 0, hs_val = 0, lp_sel = 0, lp_val = 0;
  logic tx_hs_en, tx_lp_en;
  logic [3:0] status;
  int checks = 0, fails = 0;

  localparam logic [3:0] S_STOP = 4'b0100, S_NONE = 4'b0000,
                         S_ACT = 4'b0001, S_RDY = 4'b1001;

  always #2.5 clk = ~clk;

  dphy_clk_lane_seq u_dphy_clk_lane_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pwr_dn(pwr_dn),
    .hs_start(hs_start), .hs_stop(hs_stop), .tim_word(tim_word),
    .pre_tim(pre_tim), .hs_sel(hs_sel), .hs_val(hs_val), .lp_sel(lp_sel),
    .lp_val(lp_val), .tx_hs_en(tx_hs_en), .tx_lp_en(tx_lp_en), .status(status)
  );

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input string req, input logic hs, input logic lp, input logic [3:0] st);
    checks++;
    if ({tx_hs_en, tx_lp_en, status} !== {hs, lp, st}) begin
      fails++;
      $display("FAIL %s: got hs=%b lp=%b st=%b expected hs=%b lp=%b st=%b",
               req, tx_hs_en, tx_lp_en, status, hs, lp, st);
    end
  endtask

  // check n consecutive cycles of one phase, leaving the bench one cycle past it
  task automatic phase(input string req, input int n, input logic hs, input logic lp,
                       input logic [3:0] st);
    for (int i = 0; i < n; i++) begin
      chk(req, hs, lp, st);
      @(posedge clk); #1;
    end
  endtask

  function automatic int len(input logic [7:0] f);
    return (f == 0) ? 1 : int'(f);
  endfunction

  task automatic enter(input logic [31:0] w, input logic [7:0] pre, input string req);
    tim_word = w; pre_tim = pre;
    hs_start = 1; @(posedge clk); #1; hs_start = 0;
    phase({req, " R3 prepare"}, len(w[31:24]), 0, 0, S_NONE);
    phase({req, " R4 zero"},    len(w[23:16]), 1, 0, S_NONE);
    phase({req, " R5 lead"},    len(pre),      1, 0, S_ACT);
    chk({req, " R5 ready"}, 1, 0, S_RDY);
  endtask

  task automatic leave(input string req);
    hs_stop = 1; @(posedge clk); #1; hs_stop = 0;
    phase({req, " R6 post"},  len(tim_word[15:8]), 1, 0, S_ACT);
    phase({req, " R6 trail"}, len(tim_word[7:0]),  1, 0, S_NONE);
    chk({req, " R6 back to stop"}, 0, 1, S_STOP);
  endtask

  task automatic t_reset();
    chk("R1 reset state", 0, 1, S_STOP);
    checks++;
    if (status[1] !== 1'b0) begin fails++; $display("FAIL R12 ulps=%b expected 0", status[1]); end
  endtask

  task automatic t_seq_a(); enter(32'h03040502, 8'd2, "R2 seqA"); repeat (3) begin @(posedge clk); #1; end
    chk("R5 ready held", 1, 0, S_RDY); leave("R2 seqA"); endtask

  task automatic t_seq_b(); enter(32'h01020103, 8'd6, "R2 seqB"); leave("R2 seqB"); endtask

  task automatic t_zero(); enter(32'h00000000, 8'd0, "R7 zero fields"); leave("R7 zero fields"); endtask

  task automatic t_ignored();
    hs_stop = 1;
    enter(32'h02020202, 8'd2, "R8 stop held");
    @(posedge clk); #1; hs_stop = 0;
    phase("R8 post", 2, 1, 0, S_ACT);
    phase("R8 trail", 2, 1, 0, S_NONE);
    chk("R8 stop", 0, 1, S_STOP);
    enter(32'h01010101, 8'd1, "R8 start in ready");
    hs_start = 1; repeat (3) begin @(posedge clk); #1; end
    chk("R8 start ignored when ready", 1, 0, S_RDY);
    hs_start = 0; leave("R8");
  endtask

  task automatic t_override();
    hs_sel = 1; hs_val = 1; #1;
    chk("R9 hs forced", 1, 1, S_STOP);
    lp_sel = 1; lp_val = 0; #1;
    chk("R9 lp forced", 1, 0, S_STOP);
    @(posedge clk); #1;
    chk("R9 fsm untouched", 1, 0, S_STOP);
    hs_sel = 0; lp_sel = 0; #1;
    chk("R9 released", 0, 1, S_STOP);
  endtask

  task automatic t_pwrdn();
    enter(32'h01010101, 8'd1, "R10 setup");
    hs_sel = 1; hs_val = 1; lp_sel = 1; lp_val = 1;
    pwr_dn = 1; #1;
    chk("R10 idle now", 0, 0, S_NONE);
    @(posedge clk); #1;
    hs_sel = 0; lp_sel = 0; pwr_dn = 0; #1;
    chk("R10 stop after power-down", 0, 1, S_STOP);
  endtask

  task automatic t_softrst();
    tim_word = 32'h01080101; pre_tim = 8'd1;
    hs_start = 1; @(posedge clk); #1; hs_start = 0;
    @(posedge clk); #1; @(posedge clk); #1;
    chk("R11 in zero", 1, 0, S_NONE);
    soft_rst = 1; @(posedge clk); #1; soft_rst = 0;
    chk("R11 stop after soft reset", 0, 1, S_STOP);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_seq_a();
    t_seq_b();
    t_zero();
    t_ignored();
    t_override();
    t_pwrdn();
    t_softrst();
    report();
  end
endmodule